// File: doc/BRIEF.md
# Sector-Erasable Parallel Flash Emulator

This block is a synthesizable, scaled-down stand-in for a byte-wide parallel flash memory. It is meant to sit in a controller testbench as the device under the controller's control. It holds its bytes in a small on-chip array. Reads follow active-low chip-enable and output-enable. Writes are command strobes taken on the rising edge of an active-low write enable. The bidirectional data bus appears as a separate input, output and output-enable.

Writes are grouped into unlock sequences that request a byte program, the erase of one 512-byte sector, or the erase of the whole chip. Each operation then runs on its own for a parameterised number of clock cycles. During that time a read returns a status byte instead of array data. One status bit carries the complement of the bit being written. A second status bit flips on every completed read. A boot region of one or more sectors sits at the top or the bottom of the address space, as a parameter selects. When the lock input is high, that region cannot be altered. A supply-low input blocks all modifications.

Top module: `flash_emu`

## Requirements
- R1: After reset every byte reads 8'hFF. `dq_oe` is high exactly when `ce_n` and `oe_n` are both low, and outside a busy period `dq_out` shows the byte at `addr`.
- R2: The writes (11'h555, 8'hAA), (11'h2AA, 8'h55), (11'h555, 8'hA0) followed by a fourth write (A, D) program byte A to old AND D. Programming can only clear bits. Address matching uses the low 11 address bits.
- R3: Any write that breaks an expected unlock step returns the command logic to read mode, and nothing is modified.
- R4: During a busy period a read returns bit 7 as the complement of the programmed data's bit 7, or 0 during an erase. Bits 5..0 read 0. After completion, reads return the true data.
- R5: During a busy period bit 6 of the status inverts between consecutive reads. Once the operation ends, repeated reads return identical data.
- R6: The writes 555/AA, 2AA/55, 555/80, 555/AA, 2AA/55 followed by (S, 8'h30) erase to 8'hFF only the sector that holds address S (sector = address >> 9). All other sectors are left unchanged.
- R7: The same five-write prefix followed by (11'h555, 8'h10) erases every sector except a locked boot region.
- R8: The boot region is the top BOOT_SECTORS sectors when BOOT_AT_TOP=1, and the bottom ones otherwise. With `boot_lock` high, a program or sector erase aimed there is dropped and no busy period starts.
- R9: While `low_supply` is high, program and erase requests are dropped and no busy period starts.
- R10: Write strobes that arrive during a busy period are ignored.
- R11: A busy period lasts at least T_PROG cycles for a program, T_SERASE cycles for a sector erase, and T_CERASE cycles for a chip erase.
- R12: A write strobe counts only if `ce_n` is low and `oe_n` is high when `we_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; command taken on its rising edge |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus, inbound half |
| dq_out | output | 8 | Data bus, outbound half (array byte or status) |
| dq_oe | output | 1 | Drive enable for the data bus |
| low_supply | input | 1 | Supply-low indication; blocks all modifications |
| boot_lock | input | 1 | Locks the boot region against program and sector erase |

## Verification
The assertions check on every cycle the rules for the command pulse: it lasts one cycle and never appears while busy. They also check that a busy period begins only after a request, and that the supply-low and boot-lock conditions keep a request from starting one. On top of that, a program write only clears bits and the status toggle bit holds still when idle. Other properties need whole scenarios, and only the bench's scenarios can show them. These are the unlock sequences and their rejection after a wrong step, erase confinement to one sector, chip erase sparing a locked boot region, the polarity of the polling bits, and the minimum length of each busy period.

// File: rtl/flash_emu_pkg.sv
`timescale 1ns/1ps
package flash_emu_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_SECT_ERASE = 2'd1,
        OP_CHIP_ERASE = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        CS_READ      = 3'd0,
        CS_UNLK1     = 3'd1,
        CS_UNLK2     = 3'd2,
        CS_PROG_DATA = 3'd3,
        CS_ERS_ARM   = 3'd4,
        CS_ERS_UNLK1 = 3'd5,
        CS_ERS_UNLK2 = 3'd6
    } cmd_state_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [7:0] data;
    } op_req_t;

    localparam int          UNLOCK_AW   = 11;
    localparam logic [10:0] KEY_ADDR_A  = 11'h555;
    localparam logic [10:0] KEY_ADDR_B  = 11'h2AA;
    localparam logic [7:0]  KEY_A       = 8'hAA;
    localparam logic [7:0]  KEY_B       = 8'h55;
    localparam logic [7:0]  OPC_PROG    = 8'hA0;
    localparam logic [7:0]  OPC_ERASE   = 8'h80;
    localparam logic [7:0]  OPC_CHIP    = 8'h10;
    localparam logic [7:0]  OPC_SECT    = 8'h30;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    // True when the sector index lies inside the boot region.
    function automatic logic in_boot(input int unsigned sect,
                                     input int unsigned nsect,
                                     input int unsigned nboot,
                                     input bit          at_top);
        if (at_top) return sect >= (nsect - nboot);
        else        return sect < nboot;
    endfunction

endpackage

// File: rtl/fe_array.sv
`timescale 1ns/1ps
module fe_array
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_and,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (wr_en) begin
            if (wr_and) mem[wr_addr] <= mem[wr_addr] & wr_data;
            else        mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R2: a program write never leaves a bit set where the data had a zero
    a_r2_prog_clears_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_and) |=> ((mem[$past(wr_addr)] & ~$past(wr_data)) == 8'h00));

endmodule

// File: rtl/fe_cmd_decode.sv
`timescale 1ns/1ps
module fe_cmd_decode
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              busy,
    output logic              req_valid,
    output op_req_t           req,
    output logic [ADDR_W-1:0] req_addr
);
    logic       we_q;
    logic       strobe;
    cmd_state_e st;
    logic [UNLOCK_AW-1:0] a_lo;
    logic       hit_a, hit_b;

    assign a_lo   = addr[UNLOCK_AW-1:0];
    assign hit_a  = (a_lo == KEY_ADDR_A);
    assign hit_b  = (a_lo == KEY_ADDR_B);
    assign strobe = !we_q && we_n && !ce_n && oe_n && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q      <= 1'b1;
            st        <= CS_READ;
            req_valid <= 1'b0;
            req       <= '{kind: OP_PROG, data: 8'h00};
            req_addr  <= '0;
        end else begin
            we_q      <= we_n;
            req_valid <= 1'b0;
            if (strobe) begin
                st <= CS_READ;
                unique case (st)
                    CS_READ:      if (hit_a && din == KEY_A) st <= CS_UNLK1;
                    CS_UNLK1:     if (hit_b && din == KEY_B) st <= CS_UNLK2;
                    CS_UNLK2: begin
                        if (hit_a && din == OPC_PROG)       st <= CS_PROG_DATA;
                        else if (hit_a && din == OPC_ERASE) st <= CS_ERS_ARM;
                    end
                    CS_PROG_DATA: begin
                        req_valid <= 1'b1;
                        req       <= '{kind: OP_PROG, data: din};
                        req_addr  <= addr;
                    end
                    CS_ERS_ARM:   if (hit_a && din == KEY_A) st <= CS_ERS_UNLK1;
                    CS_ERS_UNLK1: if (hit_b && din == KEY_B) st <= CS_ERS_UNLK2;
                    CS_ERS_UNLK2: begin
                        if (hit_a && din == OPC_CHIP) begin
                            req_valid <= 1'b1;
                            req       <= '{kind: OP_CHIP_ERASE, data: din};
                            req_addr  <= addr;
                        end else if (din == OPC_SECT) begin
                            req_valid <= 1'b1;
                            req       <= '{kind: OP_SECT_ERASE, data: din};
                            req_addr  <= addr;
                        end
                    end
                    default: st <= CS_READ;
                endcase
            end
        end
    end

    // R12: one strobe gives at most a single-cycle request
    a_r12_req_single: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);
    // R10: no request is raised during a busy period
    a_r10_no_req_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !busy);

endmodule

// File: rtl/fe_op_engine.sv
`timescale 1ns/1ps
module fe_op_engine
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int SECT_W       = 9,
    parameter int BOOT_SECTORS = 1,
    parameter bit BOOT_AT_TOP  = 1'b1,
    parameter int T_PROG       = 16,
    parameter int T_SERASE     = 600,
    parameter int T_CERASE     = 2100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              low_supply,
    input  logic              boot_lock,
    output logic              busy,
    output op_kind_e          cur_kind,
    output logic [7:0]        cur_data,
    output logic              wr_en,
    output logic              wr_and,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int NSECT = 1 << (ADDR_W - SECT_W);
    localparam int TMAX  = (T_CERASE > T_SERASE) ?
                           ((T_CERASE > T_PROG) ? T_CERASE : T_PROG) :
                           ((T_SERASE > T_PROG) ? T_SERASE : T_PROG);
    localparam int TW    = $clog2(TMAX + 1);

    logic [TW-1:0]     timer;
    logic [ADDR_W-1:0] addr_q, sweep_ptr, sweep_last;
    logic              sweep_done, lock_q;
    logic              req_boot, ptr_boot, accept;

    assign req_boot = in_boot(32'(req_addr[ADDR_W-1:SECT_W]), NSECT, BOOT_SECTORS, BOOT_AT_TOP);
    assign ptr_boot = in_boot(32'(sweep_ptr[ADDR_W-1:SECT_W]), NSECT, BOOT_SECTORS, BOOT_AT_TOP);
    assign accept   = req_valid && !busy && !low_supply &&
                      !(boot_lock && req_boot && req.kind != OP_CHIP_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cur_kind   <= OP_PROG;
            cur_data   <= 8'h00;
            addr_q     <= '0;
            timer      <= '0;
            sweep_ptr  <= '0;
            sweep_last <= '0;
            sweep_done <= 1'b1;
            lock_q     <= 1'b0;
        end else if (accept) begin
            busy     <= 1'b1;
            cur_kind <= req.kind;
            cur_data <= req.data;
            addr_q   <= req_addr;
            lock_q   <= boot_lock;
            unique case (req.kind)
                OP_PROG: begin
                    timer      <= TW'(T_PROG - 1);
                    sweep_done <= 1'b1;
                end
                OP_SECT_ERASE: begin
                    timer      <= TW'(T_SERASE - 1);
                    sweep_done <= 1'b0;
                    sweep_ptr  <= {req_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                    sweep_last <= {req_addr[ADDR_W-1:SECT_W], {SECT_W{1'b1}}};
                end
                default: begin
                    timer      <= TW'(T_CERASE - 1);
                    sweep_done <= 1'b0;
                    sweep_ptr  <= '0;
                    sweep_last <= '1;
                end
            endcase
        end else if (busy) begin
            if (!sweep_done) begin
                if (sweep_ptr == sweep_last) sweep_done <= 1'b1;
                else                         sweep_ptr  <= sweep_ptr + 1'b1;
            end
            if (timer != '0) timer <= timer - 1'b1;
            else if (sweep_done) busy <= 1'b0;
        end
    end

    always_comb begin
        wr_and  = (cur_kind == OP_PROG);
        wr_addr = sweep_done ? addr_q : sweep_ptr;
        wr_data = sweep_done ? cur_data : ERASED_BYTE;
        wr_en   = busy && ((!sweep_done && !(lock_q && ptr_boot)) ||
                           (cur_kind == OP_PROG && timer == '0));
    end

    // R11: a busy period only opens after a request
    a_r11_busy_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));
    // R9: supply-low blocks the start of any operation
    a_r9_supply_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && low_supply && !busy) |=> !busy);
    // R8: a locked boot target never starts a program or sector erase
    a_r8_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && boot_lock && req_boot && req.kind != OP_CHIP_ERASE) |=> !busy);

endmodule

// File: rtl/flash_emu.sv
`timescale 1ns/1ps
module flash_emu
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int SECT_W       = 9,
    parameter int BOOT_SECTORS = 1,
    parameter bit BOOT_AT_TOP  = 1'b1,
    parameter int T_PROG       = 16,
    parameter int T_SERASE     = 600,
    parameter int T_CERASE     = 2100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic              low_supply,
    input  logic              boot_lock
);
    logic              req_valid;
    op_req_t           req;
    logic [ADDR_W-1:0] req_addr;
    logic              busy;
    op_kind_e          cur_kind;
    logic [7:0]        cur_data;
    logic              wr_en, wr_and;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, rd_data;
    logic              rd_act, rd_q, tog;

    fe_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(dq_in), .busy(busy),
        .req_valid(req_valid), .req(req), .req_addr(req_addr)
    );

    fe_op_engine #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .BOOT_SECTORS(BOOT_SECTORS),
        .BOOT_AT_TOP(BOOT_AT_TOP), .T_PROG(T_PROG), .T_SERASE(T_SERASE),
        .T_CERASE(T_CERASE)
    ) u_eng (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req(req),
        .req_addr(req_addr), .low_supply(low_supply), .boot_lock(boot_lock),
        .busy(busy), .cur_kind(cur_kind), .cur_data(cur_data),
        .wr_en(wr_en), .wr_and(wr_and), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fe_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_and(wr_and),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
    );

    assign rd_act = !ce_n && !oe_n;
    assign dq_oe  = rd_act;

    // Status bit 6 flips when a read access ends during a busy period.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (busy && rd_q && !rd_act) tog <= ~tog;
        end
    end

    always_comb begin
        if (busy)
            dq_out = {(cur_kind == OP_PROG) ? ~cur_data[7] : 1'b0, tog, 6'b000000};
        else
            dq_out = rd_data;
    end

    // R5: the toggle bit holds still outside busy periods
    a_r5_toggle_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(tog));

endmodule

// File: tb/test_flash_emu.sv
`timescale 1ns/1ps
module test_flash_emu;
    import flash_emu_pkg::*;

    localparam int AW       = 11;
    localparam int T_PROG   = 16;
    localparam int T_SERASE = 600;
    localparam int T_CERASE = 2100;

    logic          clk = 1'b0, rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          low_supply = 1'b0, boot_lock = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = 8'h00;
    logic [7:0]    dq_out;
    logic          dq_oe;

    flash_emu #(.ADDR_W(AW), .T_PROG(T_PROG), .T_SERASE(T_SERASE),
                .T_CERASE(T_CERASE)) i_flash_emu (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .low_supply(low_supply), .boot_lock(boot_lock)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        logic       exp_oe;
        string      tag;
    } item_t;

    item_t sbq[$];
    event  smp;
    int    total = 0, bad = 0;
    bit    finished = 1'b0;

    // Monitor: pops one expectation per sample event and compares.
    initial begin
        forever begin
            @(smp);
            if (sbq.size() != 0) begin
                item_t it;
                it = sbq.pop_front();
                total++;
                if (dq_oe !== it.exp_oe ||
                    (it.exp_oe && ((dq_out & it.mask) !== (it.exp & it.mask)))) begin
                    bad++;
                    $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h (mask %02h)",
                             it.tag, dq_oe, dq_out, it.exp_oe, it.exp, it.mask);
                end
            end
        end
    end

    task automatic check_cond(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] e,
                             input logic [7:0] m, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        sbq.push_back('{exp: e, mask: m, exp_oe: 1'b1, tag: tag});
        -> smp;
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        sbq.push_back('{exp: 8'h00, mask: 8'h00, exp_oe: 1'b0, tag: tag});
        -> smp;
        #1;
    endtask

    task automatic raw_rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dq_out;
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit oe_low);
        @(negedge clk);
        addr = a; dq_in = d; ce_n = 1'b0; oe_n = ~oe_low; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic cmd_prog(input logic [AW-1:0] a, input logic [7:0] d);
        bus_wr(11'h555, 8'hAA, 1'b0);
        bus_wr(11'h2AA, 8'h55, 1'b0);
        bus_wr(11'h555, 8'hA0, 1'b0);
        bus_wr(a, d, 1'b0);
    endtask

    task automatic erase_prefix();
        bus_wr(11'h555, 8'hAA, 1'b0);
        bus_wr(11'h2AA, 8'h55, 1'b0);
        bus_wr(11'h555, 8'h80, 1'b0);
        bus_wr(11'h555, 8'hAA, 1'b0);
        bus_wr(11'h2AA, 8'h55, 1'b0);
    endtask

    task automatic wait_done(input logic [AW-1:0] a);
        logic [7:0] v1, v2;
        for (int i = 0; i < 4000; i++) begin
            raw_rd(a, v1);
            raw_rd(a, v2);
            if (v1 == v2) break;
        end
    endtask

    initial begin
        logic [7:0] v;
        int t0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and read gating
        expect_idle("R1 no drive while deselected");
        expect_rd(11'h000, 8'hFF, 8'hFF, "R1 erased after reset");
        expect_rd(11'h7FF, 8'hFF, 8'hFF, "R1 erased after reset top");

        // R2/R4/R5/R11: program with polling
        cmd_prog(11'h010, 8'h3C);
        t0 = cyc;
        expect_rd(11'h010, 8'h80, 8'hFF, "R4 program status bit7 complement");
        raw_rd(11'h010, v);
        expect_rd(11'h010, {1'b0, ~v[6], 6'b0}, 8'h40, "R5 toggle on next read");
        wait_done(11'h010);
        check_cond((cyc - t0) >= T_PROG, "R11 program busy length", cyc - t0, T_PROG);
        expect_rd(11'h010, 8'h3C, 8'hFF, "R2 programmed byte");
        expect_rd(11'h010, 8'h3C, 8'hFF, "R5 stable after completion");

        cmd_prog(11'h010, 8'hF0);
        wait_done(11'h010);
        expect_rd(11'h010, 8'h30, 8'hFF, "R2 program ANDs with old data");

        // R3: broken unlock sequence
        bus_wr(11'h555, 8'hAA, 1'b0);
        bus_wr(11'h2AA, 8'h54, 1'b0);
        bus_wr(11'h555, 8'hA0, 1'b0);
        bus_wr(11'h020, 8'h00, 1'b0);
        expect_rd(11'h020, 8'hFF, 8'hFF, "R3 wrong step aborts command");

        // R12: strobe with output enable low is not a command
        bus_wr(11'h555, 8'hAA, 1'b1);
        bus_wr(11'h2AA, 8'h55, 1'b0);
        bus_wr(11'h555, 8'hA0, 1'b0);
        bus_wr(11'h030, 8'h00, 1'b0);
        expect_rd(11'h030, 8'hFF, 8'hFF, "R12 strobe with oe low ignored");

        // R6/R10: sector erase with a command issued while busy
        cmd_prog(11'h200, 8'h11);
        wait_done(11'h200);
        expect_rd(11'h200, 8'h11, 8'hFF, "R2 program sector 1");
        erase_prefix();
        bus_wr(11'h2A0, 8'h30, 1'b0);
        t0 = cyc;
        expect_rd(11'h200, 8'h00, 8'h80, "R4 erase status bit7 zero");
        cmd_prog(11'h050, 8'h00);
        wait_done(11'h200);
        check_cond((cyc - t0) >= T_SERASE, "R11 sector erase busy length", cyc - t0, T_SERASE);
        expect_rd(11'h200, 8'hFF, 8'hFF, "R6 addressed sector erased");
        expect_rd(11'h010, 8'h30, 8'hFF, "R6 other sector untouched");
        expect_rd(11'h050, 8'hFF, 8'hFF, "R10 program during busy ignored");

        // R8: boot region (top sector) lock
        boot_lock = 1'b0;
        cmd_prog(11'h7F0, 8'h5A);
        wait_done(11'h7F0);
        expect_rd(11'h7F0, 8'h5A, 8'hFF, "R8 unlocked boot program");
        boot_lock = 1'b1;
        cmd_prog(11'h700, 8'h80);
        expect_rd(11'h700, 8'hFF, 8'hFF, "R8 locked program no busy");
        erase_prefix();
        bus_wr(11'h7F0, 8'h30, 1'b0);
        expect_rd(11'h7F0, 8'h5A, 8'hFF, "R8 locked sector erase no busy");
        repeat (20) @(negedge clk);
        expect_rd(11'h7F0, 8'h5A, 8'hFF, "R8 boot data kept");

        // R9: supply-low inhibit
        low_supply = 1'b1;
        cmd_prog(11'h060, 8'h80);
        expect_rd(11'h060, 8'hFF, 8'hFF, "R9 supply low blocks program");
        erase_prefix();
        bus_wr(11'h010, 8'h30, 1'b0);
        expect_rd(11'h010, 8'h30, 8'hFF, "R9 supply low blocks erase");
        low_supply = 1'b0;

        // R7: chip erase spares the locked boot region
        erase_prefix();
        bus_wr(11'h555, 8'h10, 1'b0);
        t0 = cyc;
        expect_rd(11'h010, 8'h00, 8'h80, "R4 chip erase status bit7 zero");
        wait_done(11'h010);
        check_cond((cyc - t0) >= T_CERASE, "R11 chip erase busy length", cyc - t0, T_CERASE);
        expect_rd(11'h010, 8'hFF, 8'hFF, "R7 chip erase clears sector 0");
        expect_rd(11'h7F0, 8'h5A, 8'hFF, "R7 locked boot survives chip erase");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule